// File: doc/BRIEF.md
# Flash Array Power and Program-Voltage Control

This block is the control-register logic of an on-chip flash array controller. It holds four state bits: a stop bit, a freeze-policy bit, a register lock bit and a program/erase enable bit. From these bits it drives the enable of the program/erase high-voltage supply and a flag that tells the system-bus slave whether array accesses may be served. It also drives the enable of a secondary port that supplies microcode straight from the array.

Stop is a suspend, not an abort. Setting stop removes the high voltage and refuses system-bus accesses, but the program/erase enable bit keeps its value. Clearing stop therefore brings the voltage back unless software has cleared the enable bit while stopped. The microcode port does not look at stop. While the array works as a microcode store, programming is impossible and the high voltage stays off.

The stop bit gets its reset value from a sampled data pin and from a shadow configuration bit. The freeze-policy bit chooses whether a debug freeze forces the voltage off. The lock bit write-protects the freeze-policy field, and only reset clears the lock bit.

Top module: `flash_pwr_ctl`

## Requirements
- R1: While reset is asserted, and until the first clock edge after the internal synchronised reset releases, bus_ok and pe_volt_en are 0. At that edge stop is loaded with 1 if strap_pin is 0 or shadow_stop is 1, and with 0 otherwise. The freeze-policy bit, the lock bit and the enable bit are loaded with 0.
- R2: bus_ok is 1 exactly when stop is 0. Stop is bit 0 of the control register (wr_addr 0), and any write to that register updates it.
- R3: While stop is 1, pe_volt_en is 0. The enable bit (bit 0 of the program register, wr_addr 1) keeps its value.
- R4: When stop is cleared, pe_volt_en returns to 1 if the enable bit is still 1. If the enable bit was cleared while stopped, pe_volt_en stays 0.
- R5: ucode_en equals ucode_mode whatever the value of stop.
- R6: While freeze_in is 1, pe_volt_en is forced to 0 if the freeze-policy bit (control bit 1) is 0. If the freeze-policy bit is 1, pe_volt_en follows the enable bit during freeze.
- R7: While the lock bit is 1, writes to the freeze-policy bit are ignored and it keeps its value. Stop stays writable.
- R8: Writing 1 to control bit 2 sets the lock bit. Writing 0 to that bit does not clear it. Only reset clears it.
- R9: While ucode_mode is 1, pe_volt_en is 0.
- R10: Changes on strap_pin after the reset-time sample do not affect stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strap_pin | input | 1 | Data pin level sampled once after reset; a low level requests stop |
| shadow_stop | input | 1 | Shadow configuration bit; 1 requests stop at reset |
| ucode_mode | input | 1 | Shadow configuration: 1 means the array serves the microcode port |
| freeze_in | input | 1 | Debug freeze request |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register select: 0 is control, 1 is program |
| wr_data | input | DATA_W | Write data |
| pe_volt_en | output | 1 | Program/erase high-voltage enable |
| bus_ok | output | 1 | System-bus array accesses allowed |
| ucode_en | output | 1 | Microcode port enable |

## Verification
The assertions assume that freeze_in, ucode_mode and the write port are synchronous to clk and change only between edges. They also assume that ucode_mode and shadow_stop are configuration levels that do not toggle inside a single cycle. The bench drives every input on the falling edge, so each value is settled well before the edge that samples it. Register writes last exactly one cycle. Reset is applied with strap_pin and shadow_stop held constant across the release and the sampling edge. strap_pin is moved only after that edge.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  // register select values
  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_PROG = 1;
  // control register field positions
  localparam int unsigned CTL_STOP = 0;
  localparam int unsigned CTL_FRZ  = 1;
  localparam int unsigned CTL_LOCK = 2;
  // program register field positions
  localparam int unsigned PRG_PE   = 0;

  typedef struct packed {
    logic stop;
    logic frz;
    logic lock;
    logic pe;
  } fpc_state_t;
endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  localparam int unsigned N = (STAGES < 2) ? 2 : STAGES;

  logic [N-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= 1'b0;
        else if (g == 0) chain_q[g] <= 1'b1;
        else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[N-1];
endmodule

// File: rtl/fpc_regs.sv
module fpc_regs
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic              strap_pin,
  input  logic              shadow_stop,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output fpc_state_t        st,
  output logic              init_done
);
  fpc_state_t st_q, st_d;
  logic       init_q;
  logic       st_en;
  logic       hit_ctrl, hit_prog;

  assign hit_ctrl = wr_en && (wr_addr == ADDR_W'(ADR_CTRL));
  assign hit_prog = wr_en && (wr_addr == ADDR_W'(ADR_PROG));

  // load once after reset release, then on writes
  assign st_en = !init_q || hit_ctrl || hit_prog;

  always_comb begin
    st_d = st_q;
    if (!init_q) begin
      st_d.stop = !strap_pin || shadow_stop;
      st_d.frz  = 1'b0;
      st_d.lock = 1'b0;
      st_d.pe   = 1'b0;
    end else if (hit_ctrl) begin
      st_d.stop = wr_data[CTL_STOP];
      if (!st_q.lock) st_d.frz = wr_data[CTL_FRZ];
      st_d.lock = st_q.lock | wr_data[CTL_LOCK];
    end else if (hit_prog) begin
      st_d.pe = wr_data[PRG_PE];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= '{stop: 1'b1, frz: 1'b0, lock: 1'b0, pe: 1'b0};
      init_q <= 1'b0;
    end else begin
      if (st_en) st_q <= st_d;
      if (!init_q) init_q <= 1'b1;
    end
  end

  assign st        = st_q;
  assign init_done = init_q;
endmodule

// File: rtl/fpc_hv_gate.sv
module fpc_hv_gate
  import fpc_pkg::*;
(
  input  fpc_state_t st,
  input  logic       freeze_in,
  input  logic       ucode_mode,
  output logic       pe_volt_en,
  output logic       bus_ok,
  output logic       ucode_en
);
  logic frz_block;

  always_comb begin
    frz_block  = freeze_in && !st.frz;
    pe_volt_en = st.pe && !st.stop && !frz_block && !ucode_mode;
    bus_ok     = !st.stop;
    ucode_en   = ucode_mode;
  end
endmodule

// File: rtl/flash_pwr_ctl.sv
module flash_pwr_ctl
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 1,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_pin,
  input  logic              shadow_stop,
  input  logic              ucode_mode,
  input  logic              freeze_in,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              pe_volt_en,
  output logic              bus_ok,
  output logic              ucode_en
);
  logic       rst_sync_n;
  logic       init_done;
  fpc_state_t st;

  fpc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpc_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk         (clk),
    .rst_sync_n  (rst_sync_n),
    .strap_pin   (strap_pin),
    .shadow_stop (shadow_stop),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .st          (st),
    .init_done   (init_done)
  );

  fpc_hv_gate u_gate (
    .st         (st),
    .freeze_in  (freeze_in),
    .ucode_mode (ucode_mode),
    .pe_volt_en (pe_volt_en),
    .bus_ok     (bus_ok),
    .ucode_en   (ucode_en)
  );
endmodule

// File: rtl/fpc_chk.sv
module fpc_chk
  import fpc_pkg::*;
#(
  parameter int unsigned ADDR_W = 1,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              init_done,
  input logic              freeze_in,
  input logic              ucode_mode,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              pe_volt_en,
  input logic              bus_ok,
  input fpc_state_t        st
);
  // R3: voltage never on while bus accesses are refused by stop
  p_hv_off_in_stop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ok |-> !pe_volt_en);

  // R6: freeze with policy 0 forces the voltage off
  p_hv_off_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_in && !st.frz) |-> !pe_volt_en);

  // R9: microcode mode keeps the voltage off
  p_hv_off_ucode_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ucode_mode |-> !pe_volt_en);

  // R8: lock is sticky until reset
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st.lock |=> st.lock);

  // R7: locked freeze-policy field does not move
  p_frz_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    st.lock |=> $stable(st.frz));

  // R2: a control write with stop=1 refuses the bus on the next cycle
  p_stop_blocks_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (init_done && wr_en && wr_addr == ADDR_W'(ADR_CTRL) && wr_data[CTL_STOP]) |=> !bus_ok);

  // R1: before the reset-time load, nothing is enabled
  p_pre_init_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> (!bus_ok && !pe_volt_en));
endmodule

bind flash_pwr_ctl fpc_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .init_done  (init_done),
  .freeze_in  (freeze_in),
  .ucode_mode (ucode_mode),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .pe_volt_en (pe_volt_en),
  .bus_ok     (bus_ok),
  .st         (st)
);

// File: tb/sim_flash_pwr_ctl.sv
`timescale 1ns/1ps
module sim_flash_pwr_ctl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_pin, shadow_stop, ucode_mode, freeze_in;
  logic       wr_en;
  logic [0:0] wr_addr;
  logic [7:0] wr_data;
  logic       pe_volt_en, bus_ok, ucode_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  flash_pwr_ctl u0 (
    .clk(clk), .rst_n(rst_n), .strap_pin(strap_pin), .shadow_stop(shadow_stop),
    .ucode_mode(ucode_mode), .freeze_in(freeze_in), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pe_volt_en(pe_volt_en),
    .bus_ok(bus_ok), .ucode_en(ucode_en)
  );

  typedef struct packed {
    logic [3:0] req;
    logic       frz;
    logic       uc;
    logic       we;
    logic       adr;
    logic [7:0] dat;
    logic       e_bus;
    logic       e_hv;
    logic       e_uc;
  } vec_t;

  // control (adr 0): bit0 stop, bit1 freeze policy, bit2 lock; program (adr 1): bit0 enable
  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b0}, // enable on
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b0}, // R6 freeze, policy 0
    '{4'd6, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // freeze released
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R3 stop while programming
    '{4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0}, // R2 bus refused
    '{4'd5, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1}, // R5 ucode port during stop
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R4 resume
    '{4'd6, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 1'b1, 1'b1, 1'b0}, // policy 1
    '{4'd6, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R6 freeze, policy 1
    '{4'd9, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 1'b0, 1'b1}, // R9 ucode mode
    '{4'd3, 1'b0, 1'b0, 1'b1, 1'b0, 8'h03, 1'b0, 1'b0, 1'b0}, // stop again
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0}, // enable cleared while stopped
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 1'b1, 1'b0, 1'b0}, // R4 no resume
    '{4'd4, 1'b0, 1'b0, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b0}, // enable again
    '{4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 8'h06, 1'b1, 1'b1, 1'b0}, // R8 lock set, policy 1
    '{4'd8, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // try clear lock/policy
    '{4'd7, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 1'b1, 1'b0}, // R7 policy held
    '{4'd7, 1'b0, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // stop writable under lock
    '{4'd7, 1'b1, 1'b0, 1'b1, 1'b0, 8'h02, 1'b1, 1'b1, 1'b0}  // R7 policy still 1 in freeze
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset(input logic strap, input logic shd);
    @(negedge clk);
    strap_pin = strap; shadow_stop = shd; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 bus_ok in reset", bus_ok, 1'b0);
    chk("R1 pe_volt_en in reset", pe_volt_en, 1'b0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    rst_n = 1'b0; strap_pin = 1'b1; shadow_stop = 1'b0; ucode_mode = 1'b0;
    freeze_in = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;

    // R1: strap high, shadow clear -> stop 0
    do_reset(1'b1, 1'b0);
    chk("R1 bus_ok after clean reset", bus_ok, 1'b1);
    chk("R1 pe_volt_en after reset", pe_volt_en, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      freeze_in = VEC[i].frz; ucode_mode = VEC[i].uc;
      wr_en = VEC[i].we; wr_addr = VEC[i].adr; wr_data = VEC[i].dat;
      @(negedge clk);
      wr_en = 1'b0;
      chk($sformatf("R%0d vec%0d bus_ok", VEC[i].req, i), bus_ok, VEC[i].e_bus);
      chk($sformatf("R%0d vec%0d pe_volt_en", VEC[i].req, i), pe_volt_en, VEC[i].e_hv);
      chk($sformatf("R%0d vec%0d ucode_en", VEC[i].req, i), ucode_en, VEC[i].e_uc);
    end
    freeze_in = 1'b0;

    // R8: reset clears lock, so the policy bit becomes writable again
    do_reset(1'b1, 1'b0);
    wr(1'b1, 8'h01);
    freeze_in = 1'b1;
    @(negedge clk);
    chk("R8 policy 0 after reset", pe_volt_en, 1'b0);
    wr(1'b0, 8'h02);
    chk("R8 policy writable after reset", pe_volt_en, 1'b1);
    freeze_in = 1'b0;

    // R1: strap low requests stop
    do_reset(1'b0, 1'b0);
    chk("R1 strap low -> bus refused", bus_ok, 1'b0);
    // R10: strap changes later have no effect
    strap_pin = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 strap change ignored", bus_ok, 1'b0);

    // R1: shadow bit requests stop
    do_reset(1'b1, 1'b1);
    chk("R1 shadow -> bus refused", bus_ok, 1'b0);
    shadow_stop = 1'b0;
    wr(1'b0, 8'h00);
    chk("R2 stop cleared by write", bus_ok, 1'b1);

    // R10: strap drop after clean reset
    do_reset(1'b1, 1'b0);
    strap_pin = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 strap drop ignored", bus_ok, 1'b1);

    report();
  end
endmodule